// File: doc/BRIEF.md
# Transmit Gather DMA Controller

This block builds one outgoing packet out of one or more host memory fragments. Software hands it a descriptor per fragment: a host address, a byte length, a continuation flag and a checksum-insert flag. For each descriptor the controller waits until the transmit FIFO can take the fragment, then asks an external DMA engine to read it into a staging buffer at the current fill offset. It models the DMA read time with an internal counter.

Fragments with the continuation flag set only grow the staged packet. When a fragment arrives with the flag clear, the whole staged packet is handed to the FIFO in a single push. If that last fragment asks for it, a checksum-insert request is raised on the same cycle. Every descriptor is acknowledged with a done word and a one-cycle transmit-data interrupt. Checksum arithmetic, the DMA engine itself and the line side of the FIFO belong to neighbouring blocks.

Top module: `tx_gather_dma`

## Requirements
- R1: After reset, busyErr, dmaStart, pushValid, csumReq, doneValid and irqTxData are all 0. The staged length is 0, so dmaOffset reads 0.
- R2: A descriptor presented while the controller is idle is accepted. A descriptor presented while any earlier one is still being handled raises busyErr for exactly one cycle on the next clock. That descriptor is dropped and produces no done word.
- R3: Before reading a fragment, the controller waits until fifoFree minus the bytes already staged is at least the fragment length. The controller proceeds when the two are equal. While it waits, dmaStart stays 0.
- R4: dmaStart is a one-cycle pulse. It is issued only on a cycle that follows a cycle in which dmaBusy was 0. While the pulse is high, dmaAddr, dmaLen and dmaOffset carry the fragment address, the fragment length and the staged byte count.
- R5: With room in the FIFO and dmaBusy low, doneValid rises 4 + DMA_DELAY + ceil(len/64)·DMA_FACTOR clock cycles after the clock edge that samples the descriptor.
- R6: The done word is the fragment length with bit COMPLETE_BIT (default 31) set. doneValid and irqTxData are high together for one cycle.
- R7: A fragment with more=1 pushes nothing. Its length is added to the staged count, which becomes the dmaOffset of the next fragment.
- R8: A fragment with more=0 gives one pushValid pulse, on the same cycle as doneValid. pushLen equals the total of all staged fragments, this one included. The staged count then returns to 0 for the next packet.
- R9: csumReq pulses together with pushValid when the final fragment has csum=1. The csum flag of a more=1 fragment has no effect.
- R10: While dmaBusy is 1, a fragment that has FIFO room is held and dmaStart stays 0. The read starts after dmaBusy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor write strobe |
| descAddr | input | ADDR_W | Fragment host address |
| descLen | input | LEN_W | Fragment length in bytes |
| descMore | input | 1 | Further fragments follow for this packet |
| descCsum | input | 1 | Request checksum insertion on the final fragment |
| busyErr | output | 1 | Descriptor arrived while not idle |
| fifoFree | input | FREE_W | Free bytes in the transmit FIFO |
| dmaBusy | input | 1 | DMA engine cannot accept a request |
| dmaStart | output | 1 | Read request pulse |
| dmaAddr | output | ADDR_W | Read source address |
| dmaLen | output | LEN_W | Read length |
| dmaOffset | output | STAGE_W | Destination offset in the staging buffer |
| pushValid | output | 1 | Push staged packet into the FIFO |
| pushLen | output | STAGE_W | Length of the pushed packet |
| csumReq | output | 1 | Checksum insertion request for the pushed packet |
| doneValid | output | 1 | Done word valid |
| doneWord | output | DONE_W | Fragment length with the completion bit |
| irqTxData | output | 1 | Transmit-data interrupt pulse |

## Verification
The bench builds the block with DMA_DELAY = 3 and DMA_FACTOR = 2. Every 64-byte step in fragment length therefore moves the done time by two cycles. The vector table's lengths of 1, 64, 65 and 300 cross several burst boundaries, so a rounding slip shows up in the measured latency. The default 16384-byte staging size and 17-bit free count let multi-fragment packets run well past a single burst. They also let the bench set fifoFree exactly at and one below the needed room.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWAIT,
    ST_BEGIN,
    ST_COPY,
    ST_DONE
  } txgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture the incoming descriptor
    logic dmaGo;   // read request issued this cycle
    logic finish;  // fragment copy complete
  } txgCtl_t;
endpackage

// File: rtl/txg_datapath.sv
module txg_datapath
  import txg_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 15,
  parameter int STAGE_W      = 15,
  parameter int FREE_W       = 17,
  parameter int DONE_W       = 32,
  parameter int COMPLETE_BIT = 31,
  parameter int LAT_W        = 16,
  parameter int DMA_DELAY    = 4,
  parameter int DMA_FACTOR   = 1,
  parameter int BURST_BYTES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txgCtl_t           ctl,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic              descMore,
  input  logic              descCsum,
  input  logic [FREE_W-1:0] fifoFree,
  output logic              roomOk,
  output logic [LAT_W-1:0]  copyLat,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [STAGE_W-1:0] dmaOffset,
  output logic              pushValid,
  output logic [STAGE_W-1:0] pushLen,
  output logic              csumReq,
  output logic              doneValid,
  output logic [DONE_W-1:0] doneWord,
  output logic              irqTxData
);
  localparam int BURST_SH = $clog2(BURST_BYTES);
  localparam int ROOM_W   = ((FREE_W > STAGE_W) ? FREE_W : STAGE_W) + 2;
  localparam logic [DONE_W-1:0] COMPLETE_MASK = DONE_W'(1) << COMPLETE_BIT;

  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   curLen;
  logic               curMore, curCsum;
  logic [STAGE_W-1:0] staged;
  logic [LEN_W:0]     bursts;
  logic [STAGE_W-1:0] stagedNext;

  assign bursts     = ({1'b0, curLen} + (LEN_W+1)'(BURST_BYTES - 1)) >> BURST_SH;
  assign copyLat    = LAT_W'(DMA_DELAY) + LAT_W'(bursts) * LAT_W'(DMA_FACTOR);
  assign roomOk     = ROOM_W'(fifoFree) >= (ROOM_W'(staged) + ROOM_W'(curLen));
  assign stagedNext = staged + STAGE_W'(curLen);
  assign dmaAddr    = curAddr;
  assign dmaLen     = curLen;
  assign dmaOffset  = staged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddr   <= '0;
      curLen    <= '0;
      curMore   <= 1'b0;
      curCsum   <= 1'b0;
      staged    <= '0;
      pushValid <= 1'b0;
      pushLen   <= '0;
      csumReq   <= 1'b0;
      doneValid <= 1'b0;
      doneWord  <= '0;
      irqTxData <= 1'b0;
    end else begin
      pushValid <= 1'b0;
      csumReq   <= 1'b0;
      doneValid <= 1'b0;
      irqTxData <= 1'b0;
      if (ctl.latch) begin
        curAddr <= descAddr;
        curLen  <= descLen;
        curMore <= descMore;
        curCsum <= descCsum;
      end
      if (ctl.finish) begin
        doneValid <= 1'b1;
        irqTxData <= 1'b1;
        doneWord  <= DONE_W'(curLen) | COMPLETE_MASK;
        if (curMore) begin
          staged <= stagedNext;
        end else begin
          staged    <= '0;
          pushValid <= 1'b1;
          pushLen   <= stagedNext;
          csumReq   <= curCsum;
        end
      end
    end
  end
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
  import txg_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             descValid,
  input  logic             dmaBusy,
  input  logic             roomOk,
  input  logic [LAT_W-1:0] copyLat,
  output txgCtl_t          ctl,
  output logic             dmaStart,
  output logic             busyErr
);
  txgState_e        state;
  logic [LAT_W-1:0] cnt;

  always_comb begin
    ctl.latch  = descValid && (state == ST_IDLE);
    ctl.dmaGo  = (state == ST_BEGIN) && !dmaBusy;
    ctl.finish = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      dmaStart <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      dmaStart <= ctl.dmaGo;
      busyErr  <= descValid && (state != ST_IDLE);
      unique case (state)
        ST_IDLE:  if (descValid) state <= ST_FWAIT;
        ST_FWAIT: if (roomOk) state <= ST_BEGIN;
        ST_BEGIN: if (!dmaBusy) begin
          state <= ST_COPY;
          cnt   <= copyLat;
        end
        ST_COPY: begin
          if (cnt == '0) state <= ST_DONE;
          else cnt <= cnt - 1'b1;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_gather_dma.sv
module tx_gather_dma
  import txg_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 15,
  parameter int STAGE_BYTES  = 16384,
  parameter int FREE_W       = 17,
  parameter int DONE_W       = 32,
  parameter int COMPLETE_BIT = 31,
  parameter int LAT_W        = 16,
  parameter int DMA_DELAY    = 4,
  parameter int DMA_FACTOR   = 1,
  parameter int STAGE_W      = $clog2(STAGE_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               descValid,
  input  logic [ADDR_W-1:0]  descAddr,
  input  logic [LEN_W-1:0]   descLen,
  input  logic               descMore,
  input  logic               descCsum,
  output logic               busyErr,
  input  logic [FREE_W-1:0]  fifoFree,
  input  logic               dmaBusy,
  output logic               dmaStart,
  output logic [ADDR_W-1:0]  dmaAddr,
  output logic [LEN_W-1:0]   dmaLen,
  output logic [STAGE_W-1:0] dmaOffset,
  output logic               pushValid,
  output logic [STAGE_W-1:0] pushLen,
  output logic               csumReq,
  output logic               doneValid,
  output logic [DONE_W-1:0]  doneWord,
  output logic               irqTxData
);
  txgCtl_t          ctl;
  logic             roomOk;
  logic [LAT_W-1:0] copyLat;

  txg_ctrl #(.LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .descValid(descValid), .dmaBusy(dmaBusy),
    .roomOk(roomOk), .copyLat(copyLat), .ctl(ctl), .dmaStart(dmaStart),
    .busyErr(busyErr)
  );

  txg_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STAGE_W(STAGE_W), .FREE_W(FREE_W),
    .DONE_W(DONE_W), .COMPLETE_BIT(COMPLETE_BIT), .LAT_W(LAT_W),
    .DMA_DELAY(DMA_DELAY), .DMA_FACTOR(DMA_FACTOR), .BURST_BYTES(64)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .descAddr(descAddr),
    .descLen(descLen), .descMore(descMore), .descCsum(descCsum),
    .fifoFree(fifoFree), .roomOk(roomOk), .copyLat(copyLat),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaOffset(dmaOffset),
    .pushValid(pushValid), .pushLen(pushLen), .csumReq(csumReq),
    .doneValid(doneValid), .doneWord(doneWord), .irqTxData(irqTxData)
  );
endmodule

// File: rtl/tx_gather_dma_chk.sv
module tx_gather_dma_chk #(
  parameter int DONE_W       = 32,
  parameter int COMPLETE_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              descValid,
  input logic              busyErr,
  input logic              dmaBusy,
  input logic              dmaStart,
  input logic              pushValid,
  input logic              csumReq,
  input logic              doneValid,
  input logic [DONE_W-1:0] doneWord
);
  a_r2_busy_needs_desc: assert property (@(posedge clk) disable iff (!rst_n)
    busyErr |-> $past(descValid));
  a_r4_start_after_idle_dma: assert property (@(posedge clk) disable iff (!rst_n)
    dmaStart |-> !$past(dmaBusy));
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    dmaStart |=> !dmaStart);
  a_r6_done_complete_bit: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> doneWord[COMPLETE_BIT]);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);
  a_r8_push_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pushValid |-> doneValid);
  a_r9_csum_with_push: assert property (@(posedge clk) disable iff (!rst_n)
    csumReq |-> pushValid);
endmodule

bind tx_gather_dma tx_gather_dma_chk #(
  .DONE_W(DONE_W), .COMPLETE_BIT(COMPLETE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .descValid(descValid), .busyErr(busyErr),
  .dmaBusy(dmaBusy), .dmaStart(dmaStart), .pushValid(pushValid),
  .csumReq(csumReq), .doneValid(doneValid), .doneWord(doneWord)
);

// File: tb/tx_gather_dma_bench.sv
module tx_gather_dma_bench;
  localparam int DLY = 3;
  localparam int FAC = 2;
  localparam int NV  = 7;
  localparam int VLEN  [NV] = '{64, 65, 100, 1, 200, 300, 128};
  localparam int VMORE [NV] = '{0,  1,  0,   1, 1,   0,   0};
  localparam int VCSUM [NV] = '{0,  1,  1,   0, 1,   0,   1};

  logic clk = 0, rst_n = 0;
  logic descValid = 0, descMore = 0, descCsum = 0, dmaBusy = 0;
  logic [31:0] descAddr = '0;
  logic [14:0] descLen = '0;
  logic [16:0] fifoFree = 17'd65535;
  logic busyErr, dmaStart, pushValid, csumReq, doneValid, irqTxData;
  logic [31:0] dmaAddr, doneWord;
  logic [14:0] dmaLen, dmaOffset, pushLen;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // results captured by waitDone
  int doneCyc, startCyc, startOfs, startLen, pushL;
  logic [31:0] startAddr, doneW;
  bit gotPush, gotCsum, gotIrq;

  always #10 clk = ~clk;

  tx_gather_dma #(.DMA_DELAY(DLY), .DMA_FACTOR(FAC)) u_tx_gather_dma (
    .clk(clk), .rst_n(rst_n), .descValid(descValid), .descAddr(descAddr),
    .descLen(descLen), .descMore(descMore), .descCsum(descCsum),
    .busyErr(busyErr), .fifoFree(fifoFree), .dmaBusy(dmaBusy),
    .dmaStart(dmaStart), .dmaAddr(dmaAddr), .dmaLen(dmaLen),
    .dmaOffset(dmaOffset), .pushValid(pushValid), .pushLen(pushLen),
    .csumReq(csumReq), .doneValid(doneValid), .doneWord(doneWord),
    .irqTxData(irqTxData)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendDesc(input int len, input int more, input int csum, input int addr);
    @(negedge clk);
    descValid = 1; descLen = 15'(len); descMore = more[0];
    descCsum = csum[0]; descAddr = addr;
    @(posedge clk);
    @(negedge clk);
    descValid = 0;
  endtask

  task automatic waitDone();
    int cyc = 0;
    doneCyc = -1; startCyc = -1; gotPush = 0; gotCsum = 0; gotIrq = 0;
    while (doneCyc < 0 && cyc < 300) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (dmaStart) begin
        startCyc = cyc; startOfs = dmaOffset; startLen = dmaLen; startAddr = dmaAddr;
      end
      if (doneValid) begin
        doneCyc = cyc; doneW = doneWord; gotPush = pushValid;
        pushL = pushLen; gotCsum = csumReq; gotIrq = irqTxData;
      end
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int staged = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busyErr && !dmaStart && !pushValid && !csumReq && !doneValid && !irqTxData,
        "R1 outputs idle in reset", doneValid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(dmaOffset == 0, "R1 staged zero", dmaOffset, 0);

    // table walk: R5 R6 R7 R8 R9 R4
    for (int i = 0; i < NV; i++) begin
      int lat, expPush;
      lat = DLY + ((VLEN[i] + 63) / 64) * FAC;
      sendDesc(VLEN[i], VMORE[i], VCSUM[i], 32'h1000 + i * 16);
      waitDone();
      chk(doneCyc == 4 + lat, "R5 done latency", doneCyc, 4 + lat);
      chk(doneW == (32'(VLEN[i]) | 32'h8000_0000), "R6 done word", doneW, 32'(VLEN[i]) | 32'h8000_0000);
      chk(gotIrq, "R6 irq with done", gotIrq, 1);
      chk(startCyc == 2 && startAddr == 32'h1000 + i * 16 && startLen == VLEN[i],
          "R4 start fields", startLen, VLEN[i]);
      chk(startOfs == staged, "R7 dma offset", startOfs, staged);
      if (VMORE[i] != 0) begin
        chk(!gotPush && !gotCsum, "R7 no push on more, R9 csum ignored", gotPush, 0);
        staged += VLEN[i];
      end else begin
        expPush = staged + VLEN[i];
        chk(gotPush && pushL == expPush, "R8 push length", pushL, expPush);
        chk(gotCsum == (VCSUM[i] != 0), "R9 csum on final", gotCsum, VCSUM[i]);
        staged = 0;
      end
    end

    // R3 space check counts staged bytes, boundary at equality
    sendDesc(100, 1, 0, 32'h2000);
    waitDone();
    fifoFree = 17'd299;
    sendDesc(200, 0, 0, 32'h2100);
    begin
      bit sawStart = 0;
      for (int k = 0; k < 12; k++) begin
        @(posedge clk); @(negedge clk);
        if (dmaStart) sawStart = 1;
      end
      chk(!sawStart, "R3 held one byte short", sawStart, 0);
    end
    fifoFree = 17'd300;
    waitDone();
    chk(startCyc > 0 && startOfs == 100, "R3 proceeds at equality", startOfs, 100);
    chk(gotPush && pushL == 300, "R8 push after wait", pushL, 300);
    fifoFree = 17'd65535;

    // R8 staged reset for next packet
    sendDesc(10, 0, 0, 32'h3000);
    waitDone();
    chk(startOfs == 0 && pushL == 10, "R8 staged cleared", pushL, 10);

    // R10 dmaBusy holds the read
    dmaBusy = 1;
    sendDesc(64, 0, 0, 32'h4000);
    begin
      bit sawStart = 0;
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); @(negedge clk);
        if (dmaStart) sawStart = 1;
      end
      chk(!sawStart, "R10 no start while busy", sawStart, 0);
    end
    dmaBusy = 0;
    waitDone();
    chk(startCyc > 0 && doneW == (32'd64 | 32'h8000_0000), "R10 start after release", doneW, 32'd64 | 32'h8000_0000);

    // R2 descriptor while busy is dropped
    sendDesc(64, 0, 0, 32'h5000);
    sendDesc(999, 0, 0, 32'h6000);
    chk(busyErr, "R2 busy error", busyErr, 1);
    @(posedge clk); @(negedge clk);
    chk(!busyErr, "R2 busy pulse single", busyErr, 0);
    waitDone();
    chk(doneW == (32'd64 | 32'h8000_0000), "R2 first done intact", doneW, 32'd64 | 32'h8000_0000);
    begin
      bit extra = 0;
      for (int k = 0; k < 30; k++) begin
        @(posedge clk); @(negedge clk);
        if (doneValid || dmaStart) extra = 1;
      end
      chk(!extra, "R2 dropped descriptor", extra, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule